// File: doc/BRIEF.md
# Binary to Two-Digit Decimal Converter

This block turns a 4-bit unsigned binary value (0 to 15) into two decimal digits: a tens digit that can only be 0 or 1, and a units digit from 0 to 9. It is combinational throughout. There is no clock, no register and no handshake.

The block is built from three parts:
- A comparator flags inputs above nine.
- A remap network rewrites the values 10 to 15 onto 0 to 5.
- A 4-bit two-way selector picks either the raw input or the remapped value as the units digit.

The comparator flag is used directly as the tens digit. Each digit also drives an active-low seven-segment pattern, so the block can sit straight in front of a two-digit display.

All logic is written as continuous Boolean assignments. There are no if/else or case constructs.

Top module: `bin2dec_conv`

## Requirements
- R1: `tens_o` equals 4'b0001 when `bin_i` is greater than 9, and 4'b0000 when it is 9 or less.
- R2: For `bin_i` from 0 to 9, `units_o` equals `bin_i`.
- R3: For `bin_i` from 10 to 15, `units_o` equals `bin_i` minus 10, so 10 gives 0 and 15 gives 5.
- R4: For every one of the 16 input values, `tens_o`*10 + `units_o` equals `bin_i`.
- R5: `units_o` never exceeds 9.
- R6: The segment outputs are active-low. A bit is 0 when its segment is lit. Bit 0 is segment a, bit 1 is b, and so on up to bit 6, which is g. The segments lit for each digit are:
  - 0: a b c d e f
  - 1: b c
  - 2: a b d e g
  - 3: a b c d g
  - 4: b c f g
  - 5: a c d f g
  - 6: a c d e f g
  - 7: a b c
  - 8: all seven
  - 9: a b c d f g

  `units_seg_o` shows the glyph for `units_o`.
- R7: `tens_seg_o` shows the R6 glyph for `tens_o`: 7'h40 for 0 and 7'h79 for 1.
- R8: The outputs depend only on the present input. The same `bin_i` reached from a different previous value gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bin_i | input | 4 | Unsigned binary value, 0 to 15 |
| tens_o | output | 4 | Tens digit in BCD (0 or 1) |
| units_o | output | 4 | Units digit in BCD (0 to 9) |
| tens_seg_o | output | 7 | Active-low segment pattern for the tens digit |
| units_seg_o | output | 7 | Active-low segment pattern for the units digit |

## Verification
The checker assumes only that `bin_i` carries a known value. It skips evaluation while the input holds X or Z, because every 4-bit pattern is a legal operand. The stimulus always drives fully known values: the complete 16-value space in several orders, with extra visits to the 9/10 and 15/0 edges.

// File: rtl/bin2dec_pkg.sv
package bin2dec_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SEG_W = 7;
  localparam int unsigned N_DIG = 2;
  localparam int unsigned RADIX = 10;
endpackage

// File: rtl/gt9_cmp.sv
module gt9_cmp
  import bin2dec_pkg::*;
(
  input  logic [NIB_W-1:0] val_i,
  output logic             above_o
);
  // above nine: top bit set together with bit 2 or bit 1
  assign above_o = val_i[3] & (val_i[2] | val_i[1]);
endmodule

// File: rtl/units_remap.sv
module units_remap
  import bin2dec_pkg::*;
(
  input  logic [NIB_W-1:0] val_i,
  output logic [NIB_W-1:0] fix_o
);
  // Meaningful only for 10..15; result is val_i - 10.
  assign fix_o[0] = val_i[0];
  assign fix_o[1] = ~val_i[1];
  assign fix_o[2] = val_i[2] & val_i[1];
  assign fix_o[3] = 1'b0;
endmodule

// File: rtl/nib_mux2.sv
module nib_mux2
  import bin2dec_pkg::*;
(
  input  logic             sel_i,
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  output logic [NIB_W-1:0] y_o
);
  assign y_o = ({NIB_W{~sel_i}} & a_i) | ({NIB_W{sel_i}} & b_i);
endmodule

// File: rtl/seg7_enc.sv
module seg7_enc
  import bin2dec_pkg::*;
(
  input  logic [NIB_W-1:0] dig_i,
  output logic [SEG_W-1:0] seg_n_o
);
  logic [9:0] hit;
  for (genvar k = 0; k < 10; k++) begin : g_dec
    assign hit[k] = (dig_i == NIB_W'(k));
  end
  // active-low: 1 means segment dark
  assign seg_n_o[0] = hit[1] | hit[4];
  assign seg_n_o[1] = hit[5] | hit[6];
  assign seg_n_o[2] = hit[2];
  assign seg_n_o[3] = hit[1] | hit[4] | hit[7];
  assign seg_n_o[4] = hit[1] | hit[3] | hit[4] | hit[5] | hit[7] | hit[9];
  assign seg_n_o[5] = hit[1] | hit[2] | hit[3] | hit[7];
  assign seg_n_o[6] = hit[0] | hit[1] | hit[7];
endmodule

// File: rtl/bin2dec_conv.sv
module bin2dec_conv
  import bin2dec_pkg::*;
(
  input  logic [NIB_W-1:0] bin_i,
  output logic [NIB_W-1:0] tens_o,
  output logic [NIB_W-1:0] units_o,
  output logic [SEG_W-1:0] tens_seg_o,
  output logic [SEG_W-1:0] units_seg_o
);
  logic             over9;
  logic [NIB_W-1:0] remapped;
  logic [NIB_W-1:0] dig   [N_DIG];
  logic [SEG_W-1:0] segs  [N_DIG];

  gt9_cmp     u_cmp (.val_i(bin_i), .above_o(over9));
  units_remap u_fix (.val_i(bin_i), .fix_o(remapped));
  nib_mux2    u_mux (.sel_i(over9), .a_i(bin_i), .b_i(remapped), .y_o(units_o));

  assign tens_o = {{(NIB_W-1){1'b0}}, over9};
  assign dig[0] = units_o;
  assign dig[1] = tens_o;

  for (genvar d = 0; d < N_DIG; d++) begin : g_seg
    seg7_enc u_enc (.dig_i(dig[d]), .seg_n_o(segs[d]));
  end

  assign units_seg_o = segs[0];
  assign tens_seg_o  = segs[1];
endmodule

// File: rtl/bin2dec_conv_chk.sv
module bin2dec_conv_chk
  import bin2dec_pkg::*;
(
  input logic [NIB_W-1:0] bin_i,
  input logic [NIB_W-1:0] tens_o,
  input logic [NIB_W-1:0] units_o,
  input logic [SEG_W-1:0] tens_seg_o
);
  always_comb begin
    if (!$isunknown(bin_i)) begin
      p_tens_flag_r1: assert (tens_o == ((bin_i > 4'd9) ? 4'd1 : 4'd0))
        else $error("R1 tens wrong");
      p_pass_low_r2: assert ((bin_i > 4'd9) || (units_o == bin_i))
        else $error("R2 units wrong");
      p_wrap_high_r3: assert ((bin_i <= 4'd9) || (units_o + 4'd10 == bin_i))
        else $error("R3 units wrong");
      p_sum_r4: assert (({1'b0, tens_o} * 5'd10 + {1'b0, units_o}) == {1'b0, bin_i})
        else $error("R4 sum wrong");
      p_units_bound_r5: assert (units_o <= 4'd9)
        else $error("R5 units out of range");
      p_tens_glyph_r7: assert ((tens_seg_o == 7'h40) || (tens_seg_o == 7'h79))
        else $error("R7 tens glyph");
    end
  end
endmodule

bind bin2dec_conv bin2dec_conv_chk u_chk (
  .bin_i(bin_i), .tens_o(tens_o), .units_o(units_o), .tens_seg_o(tens_seg_o)
);

// File: tb/sim_bin2dec_conv.sv
`timescale 1ns/1ps
module sim_bin2dec_conv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bin_i;
  logic [3:0] tens_o, units_o;
  logic [6:0] tens_seg_o, units_seg_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bin2dec_conv u0 (.bin_i(bin_i), .tens_o(tens_o), .units_o(units_o),
                   .tens_seg_o(tens_seg_o), .units_seg_o(units_seg_o));

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: glyph = 7'h40; 1: glyph = 7'h79; 2: glyph = 7'h24; 3: glyph = 7'h30;
      4: glyph = 7'h19; 5: glyph = 7'h12; 6: glyph = 7'h02; 7: glyph = 7'h78;
      8: glyph = 7'h00; 9: glyph = 7'h10; default: glyph = 7'h7f;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s in=%0d actual=%0d expected=%0d", req, bin_i, act, exp);
    end
  endtask

  task automatic apply(int v);
    @(posedge clk); bin_i = 4'(v);
    @(negedge clk);
  endtask

  task automatic full_check(int v);
    apply(v);
    check("R1", tens_o, v / 10);
    if (v <= 9) check("R2", units_o, v); else check("R3", units_o, v - 10);
    check("R4", tens_o * 10 + units_o, v);
    check("R5", units_o <= 9, 1);
    check("R6", units_seg_o, glyph(v % 10));
    check("R7", tens_seg_o, glyph(v / 10));
  endtask

  task automatic t_zero_start;
    full_check(0);
  endtask

  task automatic t_up_sweep;
    for (int v = 0; v < 16; v++) full_check(v);
  endtask

  task automatic t_down_sweep;
    for (int v = 15; v >= 0; v--) full_check(v);
  endtask

  task automatic t_edges;
    full_check(9); full_check(10); full_check(15); full_check(0); full_check(10); full_check(9);
  endtask

  task automatic t_history_r8;
    logic [3:0] t0, u0v; logic [6:0] s0;
    apply(3); t0 = tens_o; u0v = units_o; s0 = units_seg_o;
    apply(14); apply(3);
    check("R8", {tens_o, units_o, units_seg_o}, {t0, u0v, s0});
    apply(12); t0 = tens_o; u0v = units_o;
    apply(7); apply(12);
    check("R8", {tens_o, units_o}, {t0, u0v});
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bin_i = 4'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero_start();
    t_up_sweep();
    t_down_sweep();
    t_edges();
    t_history_r8();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule